// File: doc/BRIEF.md
# Two-Part Inter-Frame Deferral Timer

This block decides when a half-duplex 10 Mb/s Ethernet MAC may begin a transmission. It measures the quiet time on the medium in bit-time ticks and splits the required 96-bit gap into two parts. In the first part, carrier from another station sends the count back to zero. In the second part, carrier is ignored, so a pending frame goes out on schedule and any overlap becomes an ordinary collision.

After the MAC's own transmission, timing waits until both the transmit flag and carrier sense are low. A 40-bit blinding window then hides carrier sense. It covers the period in which the transceiver's self-test burst can appear. A restart of the first part never re-opens this window. A configuration input turns off the restartable first part after the MAC's own transmissions only.

The block only issues a grant. It does no backoff, collision counting or frame handling. All timing decisions are taken on cycles where `bit_tick` is high. A request raised while the gap is already satisfied is granted on the next clock.

Top module: `ifg_defer_timer`

## Requirements
- R1: Reset is synchronous and active low (`rst_n` = 0). While reset is asserted, `tx_start` is 0. After reset the block is in the gap-satisfied idle state, so a request in the first cycle after release is granted on the next clock.
- R2: While idle with the gap satisfied, a tick with carrier starts a new receive gap. Every tick with carrier holds the count at zero. The gap completes on the 96th carrier-free tick counted.
- R3: In a receive gap, carrier on a tick when fewer than 60 bit times have been counted restarts the count from zero.
- R4: Once 60 bit times have been counted, carrier on later ticks is ignored, and the gap completes at bit time 96.
- R5: After `tx_active` falls, timing starts on the first tick at which both `tx_active` and `crs` are low. That tick counts as bit time 1, and the gap completes on the 96th tick.
- R6: After the MAC's own transmission, carrier on tick 2 through tick 40 of the post-transmit gap has no effect.
- R7: With `cfg_no_tx_2part` = 0, carrier on tick 41 through tick 60 after the MAC's own transmission restarts only the count. The blinding window is not entered again, so later carrier within the first 60 counted bit times restarts the count again.
- R8: With `cfg_no_tx_2part` = 1, carrier after the MAC's own transmission is ignored for the whole of that gap, and the grant comes on tick 96.
- R9: `tx_start` is a one-clock pulse, high in the clock after the completing tick when `tx_req` is high on that tick. At most one pulse is issued until `tx_active` has been seen.
- R10: If the gap completes with `tx_req` low, the block idles. A later `tx_req` on any clock, tick or not, gives a `tx_start` pulse in the next clock.
- R11: `tx_active` high on any clock cancels any gap in progress and any pending grant. No `tx_start` follows a clock in which `tx_active` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_tick | input | 1 | One-clock enable per bit time |
| crs | input | 1 | Carrier sense from the medium |
| tx_active | input | 1 | MAC is transmitting |
| tx_req | input | 1 | A frame is waiting to be sent |
| cfg_no_tx_2part | input | 1 | 1 disables the restartable first part after own transmission |
| tx_start | output | 1 | One-clock grant to begin transmission |

## Verification
The hardest case to reach from the ports is carrier arriving after the blinding window has closed but before the first part has ended, following the MAC's own transmission. Reaching it also means showing that a second carrier burst shortly after that restart is still honoured rather than blinded. The stimulus gets there by running a transmission, a trailing echo of carrier, and then an exact number of quiet ticks before raising carrier for one tick at bit time 46, followed by another burst five ticks later. The behavioural reference model counts ticks since the post-transmit start independently of the design. It predicts the grant cycle, which is compared on every clock.

// File: rtl/ifg_pkg.sv
// Shared types for the inter-frame deferral timer.
// Assumes: a single clock domain; all users import this package.
package ifg_pkg;

    // Controller phases of the deferral timer.
    typedef enum logic [1:0] {
        ST_SAT   = 2'd0,   // gap satisfied, idle
        ST_GAP   = 2'd1,   // timing the inter-frame gap
        ST_GRANT = 2'd2,   // grant issued, waiting for transmission
        ST_ECHO  = 2'd3    // own transmission or its trailing carrier
    } ifg_state_e;

endpackage

// File: rtl/ifg_gap_counter.sv
// Bit-time counter for the inter-frame gap.
// What it does: clears, loads one or increments on controller command, and
// reports whether the second part has been reached and whether the next
// counted bit completes the gap.
// Assumes: PART1_BITS < GAP_BITS; the commands are mutually exclusive.
module ifg_gap_counter #(
    parameter int GAP_BITS   = 96,
    parameter int PART1_BITS = 60,
    parameter int CNT_W      = $clog2(GAP_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load1,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             in_part2,
    output logic             at_last
);

    localparam logic [CNT_W-1:0] PART2_START = CNT_W'(PART1_BITS);
    localparam logic [CNT_W-1:0] LAST_VAL    = CNT_W'(GAP_BITS - 1);
    localparam logic [CNT_W-1:0] ONE_VAL     = CNT_W'(1);

    // Count update under controller command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (load1) begin
            cnt <= ONE_VAL;
        end else if (inc) begin
            cnt <= cnt + ONE_VAL;
        end
    end

    // Phase flags decoded from the count.
    always_comb begin
        in_part2 = (cnt >= PART2_START);
        at_last  = (cnt == LAST_VAL);
    end

endmodule

// File: rtl/ifg_blind_window.sv
// Carrier-sense blinding window after the MAC's own transmission.
// What it does: once started, stays active until BLIND_BITS bit times,
// counting the start tick as the first, have elapsed. It is only
// re-entered by a fresh start.
// Assumes: start and stop are not asserted together.
module ifg_blind_window #(
    parameter int BLIND_BITS = 40,
    parameter int BW         = $clog2(BLIND_BITS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic tick,
    output logic active
);

    localparam logic [BW-1:0] END_VAL = BW'(BLIND_BITS);
    localparam logic [BW-1:0] ONE_VAL = BW'(1);

    logic [BW-1:0] bcnt;
    logic          run;

    // Window progress, counted in bit ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcnt <= '0;
            run  <= 1'b0;
        end else if (stop) begin
            bcnt <= '0;
            run  <= 1'b0;
        end else if (start) begin
            bcnt <= ONE_VAL;
            run  <= 1'b1;
        end else if (tick && active) begin
            bcnt <= bcnt + ONE_VAL;
        end
    end

    // Active while running and short of the window length.
    always_comb begin
        active = run && (bcnt < END_VAL);
    end

endmodule

// File: rtl/ifg_defer_fsm.sv
// Deferral controller.
// What it does: tracks the transmit/receive context, decides on each bit tick
// whether carrier restarts the gap, and issues the single-cycle grant.
// Assumes: bit_tick is a one-clock enable; tx_active has priority over all.
module ifg_defer_fsm
    import ifg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_tick,
    input  logic       crs,
    input  logic       tx_active,
    input  logic       tx_req,
    input  logic       cfg_no_tx_2part,
    input  logic       in_part2,
    input  logic       at_last,
    input  logic       blind_active,
    output logic       cnt_clr,
    output logic       cnt_load1,
    output logic       cnt_inc,
    output logic       blind_start,
    output logic       blind_stop,
    output logic       tx_start,
    output ifg_state_e state,
    output logic       post_tx
);

    ifg_state_e state_d;
    logic       post_tx_d;
    logic       start_d;
    logic       crs_seen;

    // Carrier as seen by the deferral rule after masking.
    always_comb begin
        crs_seen = crs && !blind_active && !(post_tx && cfg_no_tx_2part);
    end

    // Next-state, counter and window commands.
    always_comb begin
        state_d     = state;
        post_tx_d   = post_tx;
        start_d     = 1'b0;
        cnt_clr     = 1'b0;
        cnt_load1   = 1'b0;
        cnt_inc     = 1'b0;
        blind_start = 1'b0;
        blind_stop  = 1'b0;
        if (tx_active) begin
            state_d    = ST_ECHO;
            post_tx_d  = 1'b0;
            cnt_clr    = 1'b1;
            blind_stop = 1'b1;
        end else begin
            unique case (state)
                ST_SAT: begin
                    if (tx_req) begin
                        start_d = 1'b1;
                        state_d = ST_GRANT;
                    end else if (bit_tick && crs) begin
                        state_d   = ST_GAP;
                        post_tx_d = 1'b0;
                        cnt_clr   = 1'b1;
                    end
                end
                ST_GRANT: begin
                    state_d = ST_GRANT;
                end
                ST_ECHO: begin
                    if (bit_tick && !crs) begin
                        state_d     = ST_GAP;
                        post_tx_d   = 1'b1;
                        cnt_load1   = 1'b1;
                        blind_start = 1'b1;
                    end
                end
                ST_GAP: begin
                    if (bit_tick) begin
                        if (crs_seen && !in_part2) begin
                            cnt_clr = 1'b1;
                        end else if (at_last) begin
                            cnt_clr = 1'b1;
                            start_d = tx_req;
                            state_d = tx_req ? ST_GRANT : ST_SAT;
                        end else begin
                            cnt_inc = 1'b1;
                        end
                    end
                end
                default: state_d = ST_SAT;
            endcase
        end
    end

    // State, context and grant registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_SAT;
            post_tx  <= 1'b0;
            tx_start <= 1'b0;
        end else begin
            state    <= state_d;
            post_tx  <= post_tx_d;
            tx_start <= start_d;
        end
    end

endmodule

// File: rtl/ifg_defer_timer.sv
// Two-part inter-frame deferral timer, top level.
// What it does: times a 96-bit gap split into a restartable first part and
// a fixed second part, blinds carrier after own transmissions, and grants
// transmission with a one-clock pulse.
// Assumes: BLIND_BITS < PART1_BITS < GAP_BITS; synchronous active-low reset.
module ifg_defer_timer
    import ifg_pkg::*;
#(
    parameter int GAP_BITS   = 96,
    parameter int PART1_BITS = 60,
    parameter int BLIND_BITS = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_tick,
    input  logic crs,
    input  logic tx_active,
    input  logic tx_req,
    input  logic cfg_no_tx_2part,
    output logic tx_start
);

    localparam int CNT_W = $clog2(GAP_BITS + 1);
    localparam int BW    = $clog2(BLIND_BITS + 1);

    logic [CNT_W-1:0] gap_cnt;
    logic             in_part2;
    logic             at_last;
    logic             blind_active;
    logic             cnt_clr;
    logic             cnt_load1;
    logic             cnt_inc;
    logic             blind_start;
    logic             blind_stop;
    logic             post_tx;
    ifg_state_e       fsm_state;

    ifg_gap_counter #(
        .GAP_BITS  (GAP_BITS),
        .PART1_BITS(PART1_BITS),
        .CNT_W     (CNT_W)
    ) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cnt_clr),
        .load1   (cnt_load1),
        .inc     (cnt_inc),
        .cnt     (gap_cnt),
        .in_part2(in_part2),
        .at_last (at_last)
    );

    ifg_blind_window #(
        .BLIND_BITS(BLIND_BITS),
        .BW        (BW)
    ) u_blind (
        .clk   (clk),
        .rst_n (rst_n),
        .start (blind_start),
        .stop  (blind_stop),
        .tick  (bit_tick),
        .active(blind_active)
    );

    ifg_defer_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_tick       (bit_tick),
        .crs            (crs),
        .tx_active      (tx_active),
        .tx_req         (tx_req),
        .cfg_no_tx_2part(cfg_no_tx_2part),
        .in_part2       (in_part2),
        .at_last        (at_last),
        .blind_active   (blind_active),
        .cnt_clr        (cnt_clr),
        .cnt_load1      (cnt_load1),
        .cnt_inc        (cnt_inc),
        .blind_start    (blind_start),
        .blind_stop     (blind_stop),
        .tx_start       (tx_start),
        .state          (fsm_state),
        .post_tx        (post_tx)
    );

endmodule

// File: rtl/ifg_defer_checker.sv
// Property checker for the deferral timer, bound into the top level.
// What it does: checks grant shape, counter range, window entry and the
// restart rules across the controller, counter and window pieces.
// Assumes: attached through the bind at the end of this file.
module ifg_defer_checker
    import ifg_pkg::*;
#(
    parameter int GAP_BITS   = 96,
    parameter int PART1_BITS = 60,
    parameter int CNT_W      = $clog2(GAP_BITS + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bit_tick,
    input logic             crs,
    input logic             tx_active,
    input logic             tx_start,
    input logic [CNT_W-1:0] gap_cnt,
    input logic             blind_active,
    input ifg_state_e       state,
    input logic             post_tx
);

    localparam logic [CNT_W-1:0] P1_VAL   = CNT_W'(PART1_BITS);
    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(GAP_BITS - 1);
    localparam logic [CNT_W-1:0] ONE_VAL  = CNT_W'(1);

    // R1: a reset clock leaves the idle state and no grant
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!tx_start && state == ST_SAT));

    // R9: grant never lasts two clocks
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R11: no grant right after a transmitting clock
    a_r11_tx_blocks_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tx_active) |-> !tx_start);

    // R2: the count never reaches the full gap value
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gap_cnt <= LAST_VAL);

    // R6: the blinding window opens only when leaving the echo phase
    a_r6_blind_from_echo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(blind_active) |-> $past(state) == ST_ECHO);

    // R3: carrier in the first part of a receive gap clears the count
    a_r3_part1_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && bit_tick && crs && !post_tx && !tx_active
         && gap_cnt < P1_VAL) |=> gap_cnt == '0);

    // R4: in the second part every tick advances the count
    a_r4_part2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP && bit_tick && !tx_active && gap_cnt >= P1_VAL
         && gap_cnt < LAST_VAL) |=> gap_cnt == CNT_W'($past(gap_cnt) + ONE_VAL));

endmodule

bind ifg_defer_timer ifg_defer_checker #(
    .GAP_BITS  (GAP_BITS),
    .PART1_BITS(PART1_BITS),
    .CNT_W     (CNT_W)
) u_ifg_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bit_tick    (bit_tick),
    .crs         (crs),
    .tx_active   (tx_active),
    .tx_start    (tx_start),
    .gap_cnt     (gap_cnt),
    .blind_active(blind_active),
    .state       (fsm_state),
    .post_tx     (post_tx)
);

// File: tb/ifg_defer_timer_bench.sv
// Bench for the deferral timer: behavioural reference model compared on
// every clock, plus grant-count checks per scenario.
module ifg_defer_timer_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_tick = 1'b0;
    logic crs = 1'b0;
    logic tx_active = 1'b0;
    logic tx_req = 1'b0;
    logic cfg_no_tx_2part = 1'b0;
    logic tx_start;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int grants = 0;
    string cur_req = "R1";

    // Reference model state
    int  m_mode = 0;     // 0 idle-satisfied, 1 timing, 2 granted, 3 after-tx wait
    int  m_quiet = 0;    // bit times counted in the gap
    int  m_since = 0;    // ticks since post-transmit start, saturating at 40
    bit  m_after_tx = 0;
    bit  m_exp = 0;

    always #10 clk = ~clk;

    ifg_defer_timer u_ifg_defer_timer (
        .clk            (clk),
        .rst_n          (rst_n),
        .bit_tick       (bit_tick),
        .crs            (crs),
        .tx_active      (tx_active),
        .tx_req         (tx_req),
        .cfg_no_tx_2part(cfg_no_tx_2part),
        .tx_start       (tx_start)
    );

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        report();
    end

    // Model of the coming clock edge, written from the requirements.
    task automatic model(input bit t, input bit c, input bit a, input bit r, input bit rs);
        bit blinded;
        bit visible;
        m_exp = 1'b0;
        if (!rs) begin
            m_mode = 0; m_quiet = 0; m_since = 0; m_after_tx = 0;
        end else if (a) begin
            m_mode = 3; m_quiet = 0; m_since = 0; m_after_tx = 0;
        end else if (m_mode == 0) begin
            if (r) begin
                m_exp = 1'b1; m_mode = 2;
            end else if (t && c) begin
                m_mode = 1; m_quiet = 0; m_after_tx = 0;
            end
        end else if (m_mode == 3) begin
            if (t && !c) begin
                m_mode = 1; m_quiet = 1; m_since = 1; m_after_tx = 1;
            end
        end else if (m_mode == 1 && t) begin
            blinded = m_after_tx && (m_since < 40);
            if (m_after_tx && m_since < 40) m_since++;
            visible = c && !blinded && !(m_after_tx && cfg_no_tx_2part);
            if (visible && m_quiet < 60) begin
                m_quiet = 0;
            end else if (m_quiet == 95) begin
                m_exp = r;
                m_mode = r ? 2 : 0;
                m_quiet = 0;
            end else begin
                m_quiet++;
            end
        end
    endtask

    // One clock: compare the last edge's result, then drive the next inputs.
    task automatic step(input bit t, input bit c, input bit a, input bit r);
        @(negedge clk);
        cyc++;
        tests++;
        if (tx_start) grants++;
        if (tx_start !== m_exp) begin
            fails++;
            $display("FAIL %s: tx_start=%0b expected %0b at cycle %0d",
                     cur_req, tx_start, m_exp, cyc);
        end
        bit_tick = t; crs = c; tx_active = a; tx_req = r;
        model(t, c, a, r, rst_n);
    endtask

    task automatic ticks(input int n, input bit c, input bit a, input bit r);
        for (int i = 0; i < n; i++) begin
            step(1'b1, c, a, r);
            step(1'b0, c, a, r);
        end
    endtask

    task automatic chk_grants(input int expd);
        tests++;
        if (grants != expd) begin
            fails++;
            $display("FAIL %s: grant count=%0d expected %0d", cur_req, grants, expd);
        end
        grants = 0;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        rst_n = 1'b0;
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        grants = 0;
        step(1'b0, 1'b0, 1'b0, 1'b1);   // R1: immediate grant after reset
        cur_req = "R9";
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b0, 1'b1);
        chk_grants(1);                  // R9: one pulse only

        // R5 and R6: transmission, echo carrier, then blinded carrier
        cur_req = "R5";
        ticks(5, 1'b1, 1'b1, 1'b0);
        ticks(4, 1'b1, 1'b0, 1'b0);
        ticks(10, 1'b0, 1'b0, 1'b1);
        cur_req = "R6";
        ticks(10, 1'b1, 1'b0, 1'b1);    // ticks 11..20 blinded
        ticks(90, 1'b0, 1'b0, 1'b1);
        chk_grants(1);

        // R7: restart of the first part without re-blinding
        cur_req = "R7";
        ticks(3, 1'b1, 1'b1, 1'b0);
        ticks(45, 1'b0, 1'b0, 1'b1);
        ticks(1, 1'b1, 1'b0, 1'b1);     // tick 46: restart
        ticks(5, 1'b0, 1'b0, 1'b1);
        ticks(1, 1'b1, 1'b0, 1'b1);     // restart again, not blinded
        ticks(96, 1'b0, 1'b0, 1'b1);
        chk_grants(1);

        // R8: first part disabled after own transmission
        cur_req = "R8";
        cfg_no_tx_2part = 1'b1;
        ticks(3, 1'b1, 1'b1, 1'b0);
        ticks(45, 1'b0, 1'b0, 1'b1);
        ticks(1, 1'b1, 1'b0, 1'b1);
        ticks(5, 1'b0, 1'b0, 1'b1);
        ticks(1, 1'b1, 1'b0, 1'b1);
        ticks(50, 1'b0, 1'b0, 1'b1);
        chk_grants(1);
        cfg_no_tx_2part = 1'b0;

        // R10: gap completes with no request, then idle
        cur_req = "R10";
        ticks(2, 1'b0, 1'b1, 1'b0);
        ticks(100, 1'b0, 1'b0, 1'b0);
        chk_grants(0);

        // R2, R3, R4: receive gap from idle
        cur_req = "R2";
        ticks(5, 1'b1, 1'b0, 1'b0);
        ticks(30, 1'b0, 1'b0, 1'b0);
        cur_req = "R3";
        ticks(2, 1'b1, 1'b0, 1'b0);
        ticks(65, 1'b0, 1'b0, 1'b0);
        cur_req = "R4";
        ticks(3, 1'b1, 1'b0, 1'b1);     // bits 66..68: ignored
        ticks(40, 1'b0, 1'b0, 1'b1);
        chk_grants(1);

        // R10: late request from satisfied idle, on a non-tick clock
        cur_req = "R10";
        ticks(2, 1'b1, 1'b1, 1'b0);
        ticks(100, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b1);
        chk_grants(1);

        // R11: transmission in the middle of a gap cancels it
        cur_req = "R11";
        ticks(2, 1'b0, 1'b1, 1'b0);
        ticks(50, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b1, 1'b1);
        ticks(3, 1'b0, 1'b1, 1'b1);
        ticks(96, 1'b0, 1'b0, 1'b1);
        chk_grants(1);

        step(1'b0, 1'b0, 1'b0, 1'b0);
        report();
    end

endmodule